// File: doc/BRIEF.md
# Manchester / Differential Manchester Line Codec

This block moves bytes over a single wire using a self-clocking code, and turns the same wire back into bytes. It runs from one system clock at twice the bit rate, so every clock cycle carries exactly one half of a bit cell. A single mode input chooses the coding. In absolute mode the direction of the mid-cell edge carries the bit. In differential mode the presence or absence of an edge at the start of the cell carries the bit. Both modes use the same serialiser and the same decoder, and both always place an edge in the middle of every cell.

The transmitter accepts bytes through a valid/ready handshake and sends them least significant bit first. A byte offered before the current one ends follows it with no idle gap. The receiver does not recover bit timing by itself. The surrounding logic, which has already matched a known preamble, raises the receive enable so that the first sampled cycle is the first half of a cell. The receiver then returns each byte with a one-cycle strobe. When a cell has no mid-cell edge, the receiver drops that byte and pulses an error strobe instead.

Top module: `manch_codec`

## Requirements
- R1: After reset, `lineOut` is low, `txActive`, `rxValid` and `rxError` are low, and `txReady` is high.
- R2: In both modes, the two half-bit levels of every transmitted cell are opposite.
- R3: With `diffMode` low, a 0 bit is sent as a high half followed by a low half, and a 1 bit as a low half followed by a high half.
- R4: With `diffMode` high, the first half of a 0 bit is the inverse of the line level just before the cell, and the first half of a 1 bit is equal to it. The level before the first cell after reset is low.
- R5: A byte occupies 16 consecutive cycles, bit 0 first and bit 7 last, and `txActive` is high for exactly those cycles.
- R6: `txReady` is high whenever the transmitter is idle. An accepted byte's first half-bit is on `lineOut` in the cycle after the clock edge that accepts it.
- R7: `txReady` is also high during the final half-bit of a byte. A byte accepted then follows the previous one with no idle cycle, and differential coding continues from the previous cell's level.
- R8: While idle, `lineOut` holds the last level it drove and `txActive` is low.
- R9: With `rxEnable` high, the first clock edge samples the first half of a cell. After the 16th sampled half, `rxValid` pulses for one cycle and `rxData` holds the byte, assembled LSB first. `rxData` changes at no other time.
- R10: In differential mode, the receiver takes as its reference level the line sample from the last edge before `rxEnable` rose. After that, the reference is the second half of each decoded cell.
- R11: If any cell of a byte has two equal halves, the receiver pulses `rxError` at the end of that byte instead of `rxValid`, and `rxData` keeps its previous value.
- R12: Lowering `rxEnable` discards a partly received byte and restarts cell alignment. The next enabled byte decodes correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, one half-bit per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| diffMode | input | 1 | 0: absolute Manchester, 1: differential Manchester |
| txData | input | 8 | Byte offered for transmission |
| txValid | input | 1 | txData is valid |
| txReady | output | 1 | Transmitter will take txData at this edge |
| lineOut | output | 1 | Encoded line |
| txActive | output | 1 | lineOut is carrying a data half-bit |
| lineIn | input | 1 | Encoded line to decode |
| rxEnable | input | 1 | Decoder running; its rise marks half-bit alignment |
| rxData | output | 8 | Last correctly decoded byte |
| rxValid | output | 1 | One-cycle strobe: new byte in rxData |
| rxError | output | 1 | One-cycle strobe: byte dropped for a coding violation |

## Verification
A half-bit phase register that is wrong inverts the mid-cell edge. The halves captured from `lineOut` then disagree with the model within one or two cycles of acceptance. A bit counter that is off by one moves the end-of-byte point. The bench sees this at once as a missing or early `txReady` in the final half-bit, or as a gap between chained bytes. A stale differential reference in the decoder flips the first decoded bit, so `rxData` is wrong on the strobe 16 cycles later. An error accumulator that is not cleared turns the byte after an injected violation into a second `rxError`.

// File: rtl/manch_pkg.sv
package manch_pkg;

  // Strobes from control to datapath, transmit side
  typedef struct packed {
    logic load;     // take a new byte, drive its first half-bit
    logic advance;  // move to next bit, drive its first half-bit
    logic flip;     // mid-cell edge
  } txStbT;

  // Strobes from control to datapath, receive side
  typedef struct packed {
    logic clear;    // decoder idle: track reference, drop progress
    logic first;    // sample first half of a cell
    logic second;   // sample second half, decode the bit
    logic last;     // second half of the final bit of a byte
  } rxStbT;

endpackage

// File: rtl/manch_codec_ctrl.sv
module manch_codec_ctrl
  import manch_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  txValid,
  output logic  txReady,
  output logic  txActive,
  input  logic  rxEnable,
  output txStbT txStb,
  output rxStbT rxStb
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

  // ---------------- transmit sequencing ----------------
  logic             txBusy;
  logic             txPhase;   // 0: first half showing, 1: second half
  logic [CNT_W-1:0] txBit;
  logic             txLastHalf;
  logic             txAccept;

  assign txLastHalf = txBusy && txPhase && (txBit == LAST_IDX);
  assign txReady    = !txBusy || txLastHalf;
  assign txAccept   = txValid && txReady;
  assign txActive   = txBusy;

  always_comb begin
    txStb.load    = txAccept;
    txStb.flip    = txBusy && !txPhase;
    txStb.advance = txBusy && txPhase && !txLastHalf;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBusy  <= 1'b0;
      txPhase <= 1'b0;
      txBit   <= '0;
    end else if (txAccept) begin
      txBusy  <= 1'b1;
      txPhase <= 1'b0;
      txBit   <= '0;
    end else if (txBusy && !txPhase) begin
      txPhase <= 1'b1;
    end else if (txBusy && !txLastHalf) begin
      txPhase <= 1'b0;
      txBit   <= txBit + 1'b1;
    end else if (txLastHalf) begin
      txBusy  <= 1'b0;
      txPhase <= 1'b0;
      txBit   <= '0;
    end
  end

  // ---------------- receive sequencing ----------------
  logic             rxPhase;
  logic [CNT_W-1:0] rxBit;

  always_comb begin
    rxStb.clear  = !rxEnable;
    rxStb.first  = rxEnable && !rxPhase;
    rxStb.second = rxEnable && rxPhase;
    rxStb.last   = rxEnable && rxPhase && (rxBit == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (!rstN || !rxEnable) begin
      rxPhase <= 1'b0;
      rxBit   <= '0;
    end else if (!rxPhase) begin
      rxPhase <= 1'b1;
    end else begin
      rxPhase <= 1'b0;
      rxBit   <= (rxBit == LAST_IDX) ? '0 : rxBit + 1'b1;
    end
  end

  // ---------------- assertions ----------------
  assert_ready_when_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    !txActive |-> txReady);

  assert_accept_starts_R6: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> txActive);

  assert_rx_phase_restart_R12: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> !rxStb.second);

endmodule

// File: rtl/manch_codec_dp.sv
module manch_codec_dp
  import manch_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              diffMode,
  input  logic [DATA_W-1:0] txData,
  input  txStbT             txStb,
  output logic              lineOut,
  input  logic              lineIn,
  input  rxStbT             rxStb,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxError
);

  // First half-bit level for a bit, given the level left by the previous cell
  function automatic logic encFirst(input logic bitVal, input logic prevLvl,
                                    input logic diff);
    if (diff) return bitVal ? prevLvl : ~prevLvl;
    else      return ~bitVal;
  endfunction

  // ---------------- serialiser ----------------
  logic [DATA_W-1:0] txShift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      lineOut <= 1'b0;
    end else if (txStb.load) begin
      txShift <= txData;
      lineOut <= encFirst(txData[0], lineOut, diffMode);
    end else if (txStb.advance) begin
      txShift <= txShift >> 1;
      lineOut <= encFirst(txShift[1], lineOut, diffMode);
    end else if (txStb.flip) begin
      lineOut <= ~lineOut;
    end
  end

  // ---------------- decoder ----------------
  logic              firstSample;
  logic              refLevel;
  logic              errAcc;
  logic [DATA_W-1:0] rxShift;
  logic              decodedBit;
  logic              violation;
  logic [DATA_W-1:0] nextShift;

  assign decodedBit = diffMode ? (firstSample == refLevel) : lineIn;
  assign violation  = (firstSample == lineIn);
  assign nextShift  = {decodedBit, rxShift[DATA_W-1:1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      firstSample <= 1'b0;
      refLevel    <= 1'b0;
      errAcc      <= 1'b0;
      rxShift     <= '0;
      rxData      <= '0;
      rxValid     <= 1'b0;
      rxError     <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      rxError <= 1'b0;
      if (rxStb.clear) begin
        refLevel <= lineIn;
        errAcc   <= 1'b0;
      end
      if (rxStb.first) begin
        firstSample <= lineIn;
      end
      if (rxStb.second) begin
        refLevel <= lineIn;
        rxShift  <= nextShift;
        if (rxStb.last) begin
          errAcc <= 1'b0;
          if (errAcc || violation) begin
            rxError <= 1'b1;
          end else begin
            rxData  <= nextShift;
            rxValid <= 1'b1;
          end
        end else begin
          errAcc <= errAcc || violation;
        end
      end
    end
  end

  // ---------------- assertions ----------------
  assert_rxdata_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |-> $stable(rxData));

  assert_rx_strobes_exclusive_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(rxValid && rxError));

endmodule

// File: rtl/manch_codec.sv
module manch_codec
  import manch_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              diffMode,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  output logic              lineOut,
  output logic              txActive,
  input  logic              lineIn,
  input  logic              rxEnable,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxError
);

  txStbT txStb;
  rxStbT rxStb;

  manch_codec_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .txValid  (txValid),
    .txReady  (txReady),
    .txActive (txActive),
    .rxEnable (rxEnable),
    .txStb    (txStb),
    .rxStb    (rxStb)
  );

  manch_codec_dp #(.DATA_W(DATA_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .diffMode (diffMode),
    .txData   (txData),
    .txStb    (txStb),
    .lineOut  (lineOut),
    .lineIn   (lineIn),
    .rxStb    (rxStb),
    .rxData   (rxData),
    .rxValid  (rxValid),
    .rxError  (rxError)
  );

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !txActive |-> $stable(lineOut));

  assert_rx_single_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid || rxError) |=> !(rxValid || rxError));

  assert_rx_needs_enable_R12: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid || rxError) |-> $past(rxEnable));

endmodule

// File: tb/test_manch_codec.sv
module test_manch_codec;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       diffMode = 1'b0;
  logic [7:0] txData = 8'h00;
  logic       txValid = 1'b0;
  logic       txReady;
  logic       lineOut;
  logic       txActive;
  logic       lineIn;
  logic       rxEnable = 1'b0;
  logic [7:0] rxData;
  logic       rxValid;
  logic       rxError;
  logic       injectOn = 1'b0;
  logic       injectVal = 1'b0;

  int checks = 0;
  int errors = 0;
  logic       modelLevel = 1'b0;
  logic [7:0] lastGood = 8'h00;

  always #2 clk = ~clk;

  assign lineIn = injectOn ? injectVal : lineOut;

  manch_codec i_manch_codec (
    .clk(clk), .rstN(rstN), .diffMode(diffMode), .txData(txData),
    .txValid(txValid), .txReady(txReady), .lineOut(lineOut),
    .txActive(txActive), .lineIn(lineIn), .rxEnable(rxEnable),
    .rxData(rxData), .rxValid(rxValid), .rxError(rxError)
  );

  // bit 8 = mode (1: differential), bits 7:0 = byte
  localparam logic [8:0] VECS [0:7] = '{
    9'h1A5, 9'h000, 9'h0FF, 9'h05A, 9'h100, 9'h1FF, 9'h081, 9'h13C
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Send count bytes back to back; injectByte gets a violation in cell 1,
  // abortByte has rxEnable dropped mid-byte (-1: none).
  task automatic sendStream(input logic [8:0] seq [4], input int count,
                            input int injectByte, input int abortByte);
    logic [15:0] expHalf;
    logic        lvl;
    logic        prevSample;
    @(negedge clk);
    diffMode = seq[0][8];
    txData   = seq[0][7:0];
    txValid  = 1'b1;
    chk(txReady == 1'b1, "R6 ready when idle", int'(txReady), 1);
    @(posedge clk);
    for (int b = 0; b < count; b++) begin
      lvl = modelLevel;
      for (int i = 0; i < 8; i++) begin
        logic f;
        f = seq[b][8] ? (seq[b][i] ? lvl : ~lvl) : ~seq[b][i];
        expHalf[2*i]   = f;
        expHalf[2*i+1] = ~f;
        lvl = ~f;
      end
      modelLevel = lvl;
      prevSample = 1'b0;
      for (int h = 0; h < 16; h++) begin
        @(negedge clk);
        if (h == 0) begin
          txValid = 1'b0;
          if (b == 0) rxEnable = 1'b1;
          else begin
            // result of the previous byte, with no gap before this one
            chk(rxValid == 1'b1, "R7 chained byte decoded", int'(rxValid), 1);
            chk(rxData == seq[b-1][7:0], "R9 chained rxData", int'(rxData), int'(seq[b-1][7:0]));
            lastGood = seq[b-1][7:0];
          end
          chk(txActive == 1'b1, "R5 txActive during byte", int'(txActive), 1);
          chk(lineOut == expHalf[0], "R6 first half follows acceptance", int'(lineOut), int'(expHalf[0]));
        end
        if (b == injectByte && h == 2) begin injectOn = 1'b1; injectVal = 1'b1; end
        if (b == injectByte && h == 4) injectOn = 1'b0;
        if (b == abortByte && h == 6) rxEnable = 1'b0;
        if (seq[b][8])
          chk(lineOut == expHalf[h], "R4 differential half-bit", int'(lineOut), int'(expHalf[h]));
        else
          chk(lineOut == expHalf[h], "R3 absolute half-bit", int'(lineOut), int'(expHalf[h]));
        if (h[0]) chk(lineOut != prevSample, "R2 mid-cell edge", int'(lineOut), int'(~prevSample));
        if (h > 0) chk(rxValid == 1'b0, "R9 no strobe mid-byte", int'(rxValid), 0);
        prevSample = lineOut;
        if (h == 15 && b + 1 < count) begin
          chk(txReady == 1'b1, "R7 ready in last half-bit", int'(txReady), 1);
          txData  = seq[b+1][7:0];
          txValid = 1'b1;
        end
      end
    end
    @(negedge clk);
    if (count - 1 == injectByte) begin
      chk(rxError == 1'b1, "R11 violation flagged", int'(rxError), 1);
      chk(rxValid == 1'b0, "R11 byte dropped", int'(rxValid), 0);
      chk(rxData == lastGood, "R11 rxData kept", int'(rxData), int'(lastGood));
    end else if (count - 1 == abortByte) begin
      chk(rxValid == 1'b0 && rxError == 1'b0, "R12 aborted byte silent",
          int'({rxValid, rxError}), 0);
    end else if (seq[count-1][8]) begin
      chk(rxValid == 1'b1, "R10 differential byte decoded", int'(rxValid), 1);
      chk(rxData == seq[count-1][7:0], "R10 differential rxData", int'(rxData), int'(seq[count-1][7:0]));
      lastGood = seq[count-1][7:0];
    end else begin
      chk(rxValid == 1'b1, "R9 byte decoded", int'(rxValid), 1);
      chk(rxData == seq[count-1][7:0], "R9 rxData", int'(rxData), int'(seq[count-1][7:0]));
      lastGood = seq[count-1][7:0];
    end
    chk(txActive == 1'b0, "R8 inactive after byte", int'(txActive), 0);
    chk(lineOut == modelLevel, "R8 idle level holds", int'(lineOut), int'(modelLevel));
    rxEnable = 1'b0;
    repeat (3) @(negedge clk);
    chk(lineOut == modelLevel, "R8 idle level steady", int'(lineOut), int'(modelLevel));
    chk(rxData == lastGood, "R9 rxData unchanged while idle", int'(rxData), int'(lastGood));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [8:0] s [4];
    repeat (3) @(negedge clk);
    chk(lineOut == 1'b0, "R1 lineOut reset", int'(lineOut), 0);
    chk(txActive == 1'b0, "R1 txActive reset", int'(txActive), 0);
    chk(txReady == 1'b1, "R1 txReady reset", int'(txReady), 1);
    chk(rxValid == 1'b0 && rxError == 1'b0, "R1 rx strobes reset", int'({rxValid, rxError}), 0);
    rstN = 1'b1;
    @(negedge clk);

    // Vector table: single bytes, first in differential mode from reset level
    for (int v = 0; v < 8; v++) begin
      s[0] = VECS[v]; s[1] = 9'h0; s[2] = 9'h0; s[3] = 9'h0;
      sendStream(s, 1, -1, -1);
    end

    // R7: back-to-back absolute
    s[0] = 9'h012; s[1] = 9'h0C7; s[2] = 9'h0E0; s[3] = 9'h0;
    sendStream(s, 3, -1, -1);
    // R7: back-to-back differential, level carried between bytes
    s[0] = 9'h155; s[1] = 9'h1AA; s[2] = 9'h10F; s[3] = 9'h1F0;
    sendStream(s, 4, -1, -1);

    // R11: violation in absolute mode, then in differential mode
    s[0] = 9'h0B4; s[1] = 9'h0; s[2] = 9'h0; s[3] = 9'h0;
    sendStream(s, 1, 0, -1);
    s[0] = 9'h16D;
    sendStream(s, 1, 0, -1);
    // R11: error accumulator cleared; next byte decodes
    s[0] = 9'h03E;
    sendStream(s, 1, -1, -1);

    // R12: abort reception mid-byte, then a normal byte
    s[0] = 9'h0C3;
    sendStream(s, 1, -1, 0);
    s[0] = 9'h19E;
    sendStream(s, 1, -1, -1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule